// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block sits in the execute stage of a five-stage in-order pipeline. For each ALU source operand it compares the source register address against the destinations of the instructions now in the memory and writeback stages. It then passes the operand from one of three places: the register-file read value, the ALU result held in the memory stage, or the result being written back. When both later stages would write the same register, the younger memory-stage result wins.

When the memory-stage instruction is a load whose destination is needed by the instruction in execute, the data does not exist yet. The unit then raises a hold signal for the fetch, decode and execute barrier registers and a bubble signal for the memory-stage barrier. The load moves on to writeback, and the consumer repeats in execute. On the next cycle the consumer picks up the loaded value from writeback. A one-bit guard register makes sure a stall never lasts two cycles in a row, so the pipeline cannot lock up.

Top module: `fwd_stall_unit`

## Requirements
- R1: When a source address matches no qualifying producer, select code 0 (register file) is reported and the operand equals the register-file value.
- R2: When a source address matches a qualifying writeback destination but not a qualifying memory-stage destination, select code 2 is reported and the operand equals the writeback result.
- R3: When a source address matches a qualifying memory-stage destination, select code 1 is reported and the operand equals the memory-stage ALU result, whatever writeback holds.
- R4: A producer qualifies only if its write enable is 1 and its destination address is nonzero; a source address of 0 always takes select code 0.
- R5: In the same cycle that a load in the memory stage has a qualifying destination matching either source address, both the hold output and the bubble output are 1.
- R6: A qualifying match by a memory-stage instruction that is not a load, or a load that matches no source, leaves hold and bubble at 0.
- R7: Hold is never 1 on two consecutive clock cycles, even if the load-use condition is still present on the inputs.
- R8: While reset is low, hold and bubble are 0. The first load-use condition after reset stalls.
- R9: Placed in a pipeline, an add writing x1 followed by two consumers of x1 gives the correct chained result with no stall. A load into x1 followed by two dependent adds gives the correct result with exactly one stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_rs_addr | input | NUM_SRC x AW | Source register addresses of the execute-stage instruction |
| ex_rf_data | input | NUM_SRC x XLEN | Register-file read values for those sources |
| mem_rd_addr | input | AW | Destination address of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_result | input | XLEN | ALU result held in the memory stage |
| wb_rd_addr | input | AW | Destination address of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_result | input | XLEN | Value being written back |
| ex_operand | output | NUM_SRC x XLEN | Forwarded ALU operands |
| ex_src_sel | output | NUM_SRC x 2 | Chosen source per operand: 0 register file, 1 memory stage, 2 writeback |
| stall_hold | output | 1 | Hold fetch, decode and execute barriers |
| mem_bubble | output | 1 | Load a no-op into the memory-stage barrier |

## Verification
The operand selects, operand values, hold and bubble are all combinational on the current inputs. The bench drives inputs after the falling edge and compares all of them one nanosecond later, in the same cycle. The only state is the previous-stall guard. The reference model updates its own copy at each rising edge, so the stall expected in cycle n+1 depends on the stall predicted in cycle n. In the pipeline programs, final register values become visible only after the last writeback edge, so they are checked once the model has drained.

// File: rtl/fwd_pkg.sv
// Shared types for the forwarding and load-use stall unit.
package fwd_pkg;
    // Operand source codes reported on ex_src_sel.
    typedef enum logic [1:0] {
        SRC_REGFILE  = 2'd0,
        SRC_MEMSTAGE = 2'd1,
        SRC_WBSTAGE  = 2'd2
    } src_sel_e;
endpackage

// File: rtl/fwd_select.sv
// Source selection for one ALU operand.
// Compares one source address against the memory- and writeback-stage
// destinations. A producer counts only with write enable set and a nonzero
// destination. The memory stage wins over writeback. Purely combinational.
module fwd_select
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] rs_addr,
    input  logic [AW-1:0] mem_rd_addr,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_rd_addr,
    input  logic          wb_wr_en,
    output src_sel_e      sel,
    output logic          mem_hit
);
    logic wb_hit;

    // Qualify each producer and compare it against the source address.
    always_comb begin
        mem_hit = mem_wr_en && (mem_rd_addr != '0) && (mem_rd_addr == rs_addr);
        wb_hit  = wb_wr_en  && (wb_rd_addr  != '0) && (wb_rd_addr  == rs_addr);
    end

    // Priority: memory stage, then writeback, then the register file.
    always_comb begin
        if (mem_hit)     sel = SRC_MEMSTAGE;
        else if (wb_hit) sel = SRC_WBSTAGE;
        else             sel = SRC_REGFILE;
    end
endmodule

// File: rtl/operand_mux.sv
// Three-way operand multiplexer driven by a source code.
// Assumes the code is one of the three defined values.
module operand_mux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  src_sel_e         sel,
    input  logic [XLEN-1:0]  rf_val,
    input  logic [XLEN-1:0]  mem_val,
    input  logic [XLEN-1:0]  wb_val,
    output logic [XLEN-1:0]  y
);
    // Route the chosen source to the operand output.
    always_comb begin
        case (sel)
            SRC_MEMSTAGE: y = mem_val;
            SRC_WBSTAGE:  y = wb_val;
            default:      y = rf_val;
        endcase
    end
endmodule

// File: rtl/load_use_detect.sv
// Load-use hazard detector with a one-cycle guard.
// Raises the stall when the memory-stage instruction is a load that feeds
// any execute operand. A registered flag blocks a second consecutive stall,
// because the bubble normally clears the hazard. Assumes mem_hit already
// includes write enable and a nonzero destination.
module load_use_detect #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] mem_hit,
    input  logic               mem_is_load,
    output logic               stall
);
    logic stalled_q;
    logic hazard;

    // Combine the per-operand matches with the load flag, gated by the guard.
    always_comb begin
        hazard = mem_is_load && (|mem_hit);
        stall  = rst_n && hazard && !stalled_q;
    end

    // Remember whether the previous cycle stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) stalled_q <= 1'b0;
        else        stalled_q <= stall;
    end

    // R7
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
endmodule

// File: rtl/fwd_stall_unit.sv
// Execute-stage forwarding and load-use stall unit (top).
// For each ALU operand it picks the register-file value, the memory-stage
// ALU result or the writeback result. A matching load in the memory stage
// instead raises hold (front barriers) and bubble (memory barrier).
// Assumes the surrounding pipeline honours hold and bubble in the same cycle.
module fwd_stall_unit
    import fwd_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NREGS   = 32,
    parameter int NUM_SRC = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0][$clog2(NREGS)-1:0] ex_rs_addr,
    input  logic [NUM_SRC-1:0][XLEN-1:0]  ex_rf_data,
    input  logic [$clog2(NREGS)-1:0]      mem_rd_addr,
    input  logic                          mem_wr_en,
    input  logic                          mem_is_load,
    input  logic [XLEN-1:0]               mem_alu_result,
    input  logic [$clog2(NREGS)-1:0]      wb_rd_addr,
    input  logic                          wb_wr_en,
    input  logic [XLEN-1:0]               wb_result,
    output logic [NUM_SRC-1:0][XLEN-1:0]  ex_operand,
    output logic [NUM_SRC-1:0][1:0]       ex_src_sel,
    output logic                          stall_hold,
    output logic                          mem_bubble
);
    localparam int AW = $clog2(NREGS);

    src_sel_e           sel_w [NUM_SRC];
    logic [NUM_SRC-1:0] mem_hit_w;
    logic               stall_w;

    // One selector and one mux per ALU operand.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
        fwd_select #(.AW(AW)) u_sel (
            .rs_addr     (ex_rs_addr[i]),
            .mem_rd_addr (mem_rd_addr),
            .mem_wr_en   (mem_wr_en),
            .wb_rd_addr  (wb_rd_addr),
            .wb_wr_en    (wb_wr_en),
            .sel         (sel_w[i]),
            .mem_hit     (mem_hit_w[i])
        );

        operand_mux #(.XLEN(XLEN)) u_mux (
            .sel     (sel_w[i]),
            .rf_val  (ex_rf_data[i]),
            .mem_val (mem_alu_result),
            .wb_val  (wb_result),
            .y       (ex_operand[i])
        );

        assign ex_src_sel[i] = sel_w[i];

        // R3
        mem_fwd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_src_sel[i] == 2'd1) |-> (ex_operand[i] == mem_alu_result));

        // R2
        wb_fwd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_src_sel[i] == 2'd2) |-> (wb_wr_en && wb_rd_addr == ex_rs_addr[i]
                && wb_rd_addr != '0 && ex_operand[i] == wb_result));

        // R4
        zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_rs_addr[i] == '0) |-> (ex_src_sel[i] == 2'd0
                && ex_operand[i] == ex_rf_data[i]));
    end

    load_use_detect #(.NUM_SRC(NUM_SRC)) u_hzd (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_hit     (mem_hit_w),
        .mem_is_load (mem_is_load),
        .stall       (stall_w)
    );

    // Hold and bubble are raised together by one stall decision.
    assign stall_hold = stall_w;
    assign mem_bubble = stall_w;

    // R5
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_hold |-> (mem_is_load && mem_wr_en && mem_rd_addr != '0));
endmodule

// File: tb/fwd_stall_unit_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared every cycle, plus a small pipeline
// harness that runs two short programs through the unit.
module fwd_stall_unit_tb;
    localparam int XLEN = 32;
    localparam int AW   = 5;

    typedef struct {
        bit valid;
        bit is_load;
        int rd;
        int rs1;
        int rs2;
        int imm;
        int val;
    } instr_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0][AW-1:0]   ex_rs_addr = '0;
    logic [1:0][XLEN-1:0] ex_rf_data = '0;
    logic [AW-1:0]   mem_rd_addr = '0;
    logic            mem_wr_en = 1'b0;
    logic            mem_is_load = 1'b0;
    logic [XLEN-1:0] mem_alu_result = '0;
    logic [AW-1:0]   wb_rd_addr = '0;
    logic            wb_wr_en = 1'b0;
    logic [XLEN-1:0] wb_result = '0;
    logic [1:0][XLEN-1:0] ex_operand;
    logic [1:0][1:0]      ex_src_sel;
    logic stall_hold;
    logic mem_bubble;

    int vectors = 0;
    int errors = 0;
    bit model_prev = 1'b0;
    bit last_exp_stall = 1'b0;
    bit done = 1'b0;

    int regs [32];
    int dmem [16];
    instr_t prog [4];

    always #2.5 clk = ~clk;

    fwd_stall_unit #(.XLEN(XLEN), .NREGS(32), .NUM_SRC(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ex_rs_addr(ex_rs_addr), .ex_rf_data(ex_rf_data),
        .mem_rd_addr(mem_rd_addr), .mem_wr_en(mem_wr_en),
        .mem_is_load(mem_is_load), .mem_alu_result(mem_alu_result),
        .wb_rd_addr(wb_rd_addr), .wb_wr_en(wb_wr_en), .wb_result(wb_result),
        .ex_operand(ex_operand), .ex_src_sel(ex_src_sel),
        .stall_hold(stall_hold), .mem_bubble(mem_bubble)
    );

    // Compare every output against the behavioural expectation for this cycle.
    task automatic check_now();
        bit hz = 1'b0;
        bit exp_st;
        bit bad = 1'b0;
        for (int i = 0; i < 2; i++) begin
            bit mh, wh;
            int esel;
            logic [XLEN-1:0] eop;
            string tag;
            mh = mem_wr_en && mem_rd_addr != 0 && mem_rd_addr == ex_rs_addr[i];
            wh = wb_wr_en && wb_rd_addr != 0 && wb_rd_addr == ex_rs_addr[i];
            if (mh && mem_is_load) hz = 1'b1;
            if (mh)      begin esel = 1; eop = mem_alu_result; tag = "R3"; end
            else if (wh) begin esel = 2; eop = wb_result;      tag = "R2"; end
            else         begin esel = 0; eop = ex_rf_data[i];
                               tag = (ex_rs_addr[i] == 0) ? "R4" : "R1"; end
            if (ex_src_sel[i] !== esel[1:0] || ex_operand[i] !== eop) begin
                bad = 1'b1;
                $display("FAIL %s op%0d sel=%0d/%0h expected sel=%0d/%0h", tag, i,
                         ex_src_sel[i], ex_operand[i], esel, eop);
            end
        end
        exp_st = rst_n && hz && !model_prev;
        if (stall_hold !== exp_st || mem_bubble !== exp_st) begin
            bad = 1'b1;
            $display("FAIL %s hold=%b bubble=%b expected %b",
                     !rst_n ? "R8" : (model_prev && hz) ? "R7" : hz ? "R5" : "R6",
                     stall_hold, mem_bubble, exp_st);
        end
        vectors++;
        if (bad) errors++;
        last_exp_stall = exp_st;
    endtask

    // Advance one clock, update the model's guard, return to the falling edge.
    task automatic step();
        @(posedge clk);
        model_prev = rst_n ? last_exp_stall : 1'b0;
        @(negedge clk);
    endtask

    // Drive a load in the memory stage feeding operand 0.
    task automatic drive_load_hazard();
        ex_rs_addr[0] = 5'd3; ex_rs_addr[1] = 5'd9;
        mem_rd_addr = 5'd3; mem_wr_en = 1'b1; mem_is_load = 1'b1;
        wb_wr_en = 1'b0;
    endtask

    // Run prog[0..n-1] through a behavioural EX/MEM/WB pipeline.
    task automatic run_prog(input int n, output int stalls);
        instr_t ex, mem, wb, nwb, bub;
        int pc = 0;
        bub = '{default: 0};
        ex = bub; mem = bub; wb = bub;
        stalls = 0;
        if (n > 0) begin ex = prog[0]; pc = 1; end
        for (int cyc = 0; cyc < n + 6; cyc++) begin
            logic [XLEN-1:0] a, b;
            ex_rs_addr[0] = ex.valid ? ex.rs1[AW-1:0] : '0;
            ex_rs_addr[1] = (ex.valid && !ex.is_load) ? ex.rs2[AW-1:0] : '0;
            ex_rf_data[0] = regs[ex_rs_addr[0]];
            ex_rf_data[1] = regs[ex_rs_addr[1]];
            mem_rd_addr = mem.rd[AW-1:0]; mem_wr_en = mem.valid;
            mem_is_load = mem.valid && mem.is_load; mem_alu_result = mem.val;
            wb_rd_addr = wb.rd[AW-1:0]; wb_wr_en = wb.valid; wb_result = wb.val;
            #1;
            check_now();
            a = ex_operand[0]; b = ex_operand[1];
            if (last_exp_stall) stalls++;
            if (wb.valid && wb.rd != 0) regs[wb.rd] = wb.val;
            nwb = mem;
            if (mem.valid && mem.is_load) nwb.val = dmem[mem.val];
            if (last_exp_stall) mem = bub;
            else begin
                mem = ex;
                if (ex.valid) mem.val = ex.is_load ? (a + ex.imm) : (a + b);
                ex = (pc < n) ? prog[pc] : bub;
                if (pc < n) pc++;
            end
            wb = nwb;
            step();
        end
    endtask

    // Check one expected integer value and count it.
    task automatic check_val(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        int st;
        @(negedge clk);
        // R8: reset held with a load-use condition present.
        drive_load_hazard();
        for (int k = 0; k < 3; k++) begin #1; check_now(); step(); end
        rst_n = 1'b1;
        // R8: first hazard after reset stalls; R7: the repeat cycle does not.
        #1; check_now();
        check_val("R5 stall on first hazard", int'(stall_hold), 1);
        step();
        #1; check_now();
        check_val("R7 no back-to-back stall", int'(stall_hold), 0);
        step();
        // R6: non-load match and non-matching load.
        mem_is_load = 1'b0; #1; check_now();
        check_val("R6 non-load match", int'(stall_hold), 0);
        check_val("R3 mem forward sel", int'(ex_src_sel[0]), 1);
        step();
        mem_is_load = 1'b1; mem_rd_addr = 5'd4; #1; check_now();
        check_val("R6 load without match", int'(stall_hold), 0);
        step();
        // R4: x0 destination never forwarded.
        ex_rs_addr[0] = 5'd0; mem_rd_addr = 5'd0; wb_rd_addr = 5'd0; wb_wr_en = 1'b1;
        ex_rf_data[0] = 32'h0; #1; check_now();
        check_val("R4 x0 reads regfile", int'(ex_src_sel[0]), 0);
        step();
        // R1..R6: random vectors over a small address range.
        for (int k = 0; k < 600; k++) begin
            for (int i = 0; i < 2; i++) begin
                ex_rs_addr[i] = 5'($urandom_range(0, 3));
                ex_rf_data[i] = $urandom;
            end
            mem_rd_addr = 5'($urandom_range(0, 3));
            mem_wr_en = 1'($urandom); mem_is_load = 1'($urandom);
            mem_alu_result = $urandom;
            wb_rd_addr = 5'($urandom_range(0, 3));
            wb_wr_en = 1'($urandom); wb_result = $urandom;
            #1; check_now(); step();
        end
        // R9: add x1,x1,x2 ; add x1,x1,x1 ; add x1,x1,x2 with x1=3, x2=5.
        foreach (regs[i]) regs[i] = 0;
        regs[1] = 3; regs[2] = 5;
        prog[0] = '{1, 0, 1, 1, 2, 0, 0};
        prog[1] = '{1, 0, 1, 1, 1, 0, 0};
        prog[2] = '{1, 0, 1, 1, 2, 0, 0};
        run_prog(3, st);
        check_val("R9 add chain x1", regs[1], 21);
        check_val("R9 add chain stalls", st, 0);
        // R9: lw x1,0(x2) ; add x1,x1,x1 ; add x1,x1,x1 with x2=4, mem[4]=7.
        foreach (regs[i]) regs[i] = 0;
        foreach (dmem[i]) dmem[i] = 0;
        regs[2] = 4; dmem[4] = 7;
        prog[0] = '{1, 1, 1, 2, 0, 0, 0};
        prog[1] = '{1, 0, 1, 1, 1, 0, 0};
        prog[2] = '{1, 0, 1, 1, 1, 0, 0};
        run_prog(3, st);
        check_val("R9 load chain x1", regs[1], 28);
        check_val("R9 load chain stalls", st, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule